// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

This block is a data cache that sits between a load/store unit and a memory port one word wide. It has a parameterized number of ways, sets and words per line. It accepts byte, halfword and word loads and stores through a valid/ready handshake and keeps only one request in flight. Every store is written through to memory. A store that misses still allocates its line. A miss refills the whole line one word at a time, starting with the word that was requested and wrapping inside the line.

A separate age unit keeps a per-set recency rank for each way and names the replacement victim. A lane unit extracts and merges the addressed bytes in big-endian order. Four counters record read hits, read misses, write hits and write misses. Each of the four access classes takes its own configurable number of wait cycles. Accesses go straight to memory when the cache is built out, disabled, or the request is marked cache-inhibited.

Top module: `dcache_wt`

## Requirements
- R1: The line holds WORDS words. The set is (address / (4*WORDS)) mod SETS and the tag is (address / (4*WORDS)) / SETS. Two lines with the same set and different tags are held in different ways at the same time, and at most one way hits.
- R2: With `cache_en` low, with `req_inhibit` high, or with HAS_CACHE = 0, an access makes exactly one memory transfer. It changes no counter, allocates nothing and leaves cached words unchanged.
- R3: Every cacheable store writes memory with `mem_we` high before it responds, whether it hits or misses.
- R4: A store miss allocates its line: the refill reads memory after the write-through, and a later load of that word hits and returns the stored lanes.
- R5: A refill requests word indices w, w+1, ..., wrapping mod WORDS, where w is the requested word.
- R6: Lanes are big-endian. The byte at offset k is bits 8*(3-k)+7:8*(3-k) and maps to `mem_be[3-k]`. A halfword at offset 0 is bits 31:16 (`mem_be`=1100). A halfword at offset 2 is bits 15:0 (`mem_be`=0011). A word uses `mem_be`=1111. Loads return the lanes zero-extended in the low bits.
- R7: A store hit replaces only the addressed lanes of the cached word and leaves the other lanes unchanged.
- R8: A refill word answered with `mem_err` stops the refill, invalidates the victim way, resets its age to 0 and completes the access, with a load returning 0. The same address misses again afterwards.
- R9: Measured in clock edges from the acceptance edge to the edge that raises `rsp_valid`, with memory acknowledging in the request cycle: a load hit takes LAT_LH+2, a load miss LAT_LM+WORDS+2, a store hit LAT_SH+3, a store miss LAT_SM+WORDS+3, and any bypassed access or a refill that fails on its first word takes 2.
- R10: Each cacheable access adds exactly 1 to one of `cnt_rd_hit`, `cnt_rd_miss`, `cnt_wr_hit` or `cnt_wr_miss`.
- R11: A miss fills an invalid way first. When all ways are valid, it replaces the least recently used way, where both hits and fills count as uses.
- R12: After reset, all ways are invalid, the counters are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R13: `req_ready` stays low from acceptance until the response. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable; low forces bypass |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_inhibit | input | 1 | Cache-inhibited access |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Load data, zero-extended |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Memory write data, lane-placed |
| mem_ack | input | 1 | Memory transfer done |
| mem_err | input | 1 | Address maps to no memory region |
| mem_rdata | input | 32 | Memory read data |
| cnt_rd_hit | output | CNT_W | Load hit count |
| cnt_rd_miss | output | CNT_W | Load miss count |
| cnt_wr_hit | output | CNT_W | Store hit count |
| cnt_wr_miss | output | CNT_W | Store miss count |

## Verification
The bench builds the cache with a 16-bit address, 2 ways, 4 sets and 4 words per line. This is small enough that three tags can be pushed into one set to exercise LRU eviction. The upper half of the address space is treated as unmapped, which makes a failing refill easy to reach. The four wait counts are set to 1, 3, 2 and 4, so every access class has its own acceptance-to-response distance, and the measured latency alone shows whether a hit or miss was taken. The bench also changes memory behind the cache to prove that a hit is served from the cache and to show exactly which lanes a store hit merged.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } dc_size_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_WMEM,
    S_BYP,
    S_FILL,
    S_WAIT,
    S_DONE
  } dc_state_e;
endpackage

// File: rtl/dc_age.sv
module dc_age #(
  parameter int WAYS = 2,
  parameter int SETS = 4,
  localparam int AW = $clog2(WAYS),
  localparam int SW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_i,
  input  logic [WAYS-1:0] valid_i,
  input  logic          hit_i,
  input  logic          fill_i,
  input  logic          kill_i,
  input  logic [AW-1:0] way_i,
  output logic [AW-1:0] victim_o
);
  localparam logic [AW-1:0] TOP = AW'(WAYS - 1);

  logic [AW-1:0] age_q [SETS][WAYS];

  // Victim: first invalid way, otherwise the way with the lowest age.
  always_comb begin
    logic [AW-1:0] best;
    logic          inv;
    inv      = 1'b0;
    victim_o = '0;
    best     = age_q[set_i][0];
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_i[i] && !inv) begin
        victim_o = AW'(i);
        inv      = 1'b1;
      end
    end
    if (!inv) begin
      for (int i = 1; i < WAYS; i++) begin
        if (age_q[set_i][i] < best) begin
          best     = age_q[set_i][i];
          victim_o = AW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= '0;
    end else if (hit_i) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] > age_q[set_i][way_i])
          age_q[set_i][w] <= age_q[set_i][w] - 1'b1;
      age_q[set_i][way_i] <= TOP;
    end else if (fill_i) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] != '0)
          age_q[set_i][w] <= age_q[set_i][w] - 1'b1;
      age_q[set_i][way_i] <= TOP;
    end else if (kill_i) begin
      age_q[set_i][way_i] <= '0;
    end
  end

  // R11
  upd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({hit_i, fill_i, kill_i}) <= 1);
endmodule

// File: rtl/dc_lanes.sv
module dc_lanes
  import dcache_pkg::*;
(
  input  dc_size_e    size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] word_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rd_o,
  output logic [31:0] placed_o,
  output logic [31:0] merged_o,
  output logic [3:0]  be_o
);
  logic [4:0]  sh;
  logic [31:0] mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        sh       = 5'(8 * (3 - off_i));
        be_o     = 4'b1000 >> off_i;
        placed_o = {24'b0, wdata_i[7:0]} << sh;
        rd_o     = (word_i >> sh) & 32'h0000_00FF;
      end
      SZ_HALF: begin
        sh       = off_i[1] ? 5'd0 : 5'd16;
        be_o     = off_i[1] ? 4'b0011 : 4'b1100;
        placed_o = {16'b0, wdata_i[15:0]} << sh;
        rd_o     = (word_i >> sh) & 32'h0000_FFFF;
      end
      default: begin
        sh       = 5'd0;
        be_o     = 4'b1111;
        placed_o = wdata_i;
        rd_o     = word_i;
      end
    endcase
    mask     = {{8{be_o[3]}}, {8{be_o[2]}}, {8{be_o[1]}}, {8{be_o[0]}}};
    merged_o = (word_i & ~mask) | (placed_o & mask);
  end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WAYS      = 2,
  parameter int SETS      = 4,
  parameter int WORDS     = 4,
  parameter int CNT_W     = 16,
  parameter int LAT_W     = 4,
  parameter int LAT_LH    = 0,
  parameter int LAT_LM    = 2,
  parameter int LAT_SH    = 1,
  parameter int LAT_SM    = 3,
  parameter bit HAS_CACHE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_inhibit,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss
);
  localparam int WI_W  = $clog2(WORDS);
  localparam int SI_W  = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - 2 - WI_W - SI_W;
  localparam int DEPTH = WAYS * SETS * WORDS;

  dc_state_e         st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q, ci_q, hit_q, byp_q;
  logic [1:0]        sz_q;
  logic [31:0]       wd_q, rdata_q;
  logic [WAY_W-1:0]  hway_q, vway_q;
  logic [WI_W-1:0]   fcnt;
  logic [LAT_W-1:0]  lat_q;

  logic [TAG_W-1:0]  tag_q [WAYS][SETS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [31:0]       data_q [DEPTH];

  wire [WI_W-1:0]  a_wi = a_q[2 +: WI_W];
  wire [SI_W-1:0]  a_si = a_q[2 + WI_W +: SI_W];
  wire [TAG_W-1:0] a_tg = a_q[ADDR_W-1 -: TAG_W];
  wire [WI_W-1:0]  f_wi = a_wi + fcnt;
  wire             f_last = (fcnt == WI_W'(WORDS - 1));
  wire             byp = !HAS_CACHE || !cache_en || ci_q;

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_idx, victim, rd_way, age_way;
  logic [31:0]      cache_word, lane_src, lane_rd, placed, merged;
  logic [3:0]       be;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[a_si][w] && (tag_q[w][a_si] == a_tg);
  end

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_idx = WAY_W'(w);
  end

  wire look_hit = (st == S_LOOK) && !byp && (|hit_vec);
  wire fill_ok  = (st == S_FILL) && mem_ack && !mem_err;
  wire fill_bad = (st == S_FILL) && mem_ack && mem_err;

  assign rd_way     = (st == S_LOOK) ? hit_idx : hway_q;
  assign cache_word = data_q[{rd_way, a_si, a_wi}];
  assign lane_src   = (st == S_LOOK || st == S_WMEM) ? cache_word : mem_rdata;
  assign age_way    = look_hit ? hit_idx : vway_q;

  dc_lanes u_lanes (
    .size_i  (dc_size_e'(sz_q)),
    .off_i   (a_q[1:0]),
    .word_i  (lane_src),
    .wdata_i (wd_q),
    .rd_o    (lane_rd),
    .placed_o(placed),
    .merged_o(merged),
    .be_o    (be)
  );

  dc_age #(.WAYS(WAYS), .SETS(SETS)) u_age (
    .clk     (clk),
    .rst     (rst),
    .set_i   (a_si),
    .valid_i (vld_q[a_si]),
    .hit_i   (look_hit),
    .fill_i  (fill_ok && f_last),
    .kill_i  (fill_bad),
    .way_i   (age_way),
    .victim_o(victim)
  );

  // Data array: single write port, written by refill or by a store hit.
  wire              d_we  = fill_ok || ((st == S_WMEM) && mem_ack && hit_q && !byp_q);
  wire [WAY_W+SI_W+WI_W-1:0] d_idx = (st == S_FILL) ? {vway_q, a_si, f_wi}
                                                    : {hway_q, a_si, a_wi};
  wire [31:0]       d_wd  = (st == S_FILL) ? mem_rdata : merged;

  always_ff @(posedge clk) begin
    if (d_we) data_q[d_idx] <= d_wd;
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_rdata = rdata_q;
  assign mem_req   = (st == S_WMEM) || (st == S_BYP) || (st == S_FILL);
  assign mem_we    = (st == S_WMEM);
  assign mem_be    = (st == S_WMEM) ? be : 4'b1111;
  assign mem_wdata = placed;
  assign mem_addr  = (st == S_FILL) ? {a_tg, a_si, f_wi, 2'b00}
                                    : {a_q[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt_rd_hit  <= '0;
      cnt_rd_miss <= '0;
      cnt_wr_hit  <= '0;
      cnt_wr_miss <= '0;
      rdata_q     <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          we_q <= req_write;
          sz_q <= req_size;
          wd_q <= req_wdata;
          ci_q <= req_inhibit;
          st   <= S_LOOK;
        end
        S_LOOK: begin
          byp_q  <= byp;
          hit_q  <= !byp && (|hit_vec);
          hway_q <= hit_idx;
          vway_q <= victim;
          fcnt   <= '0;
          if (we_q) begin
            if (!byp) begin
              if (|hit_vec) cnt_wr_hit  <= cnt_wr_hit + 1'b1;
              else          cnt_wr_miss <= cnt_wr_miss + 1'b1;
            end
            st <= S_WMEM;
          end else if (byp) begin
            st <= S_BYP;
          end else if (|hit_vec) begin
            cnt_rd_hit <= cnt_rd_hit + 1'b1;
            rdata_q    <= lane_rd;
            lat_q      <= LAT_W'(LAT_LH);
            st         <= S_WAIT;
          end else begin
            cnt_rd_miss <= cnt_rd_miss + 1'b1;
            st          <= S_FILL;
          end
        end
        S_WMEM: if (mem_ack) begin
          if (byp_q) st <= S_DONE;
          else if (hit_q) begin
            lat_q <= LAT_W'(LAT_SH);
            st    <= S_WAIT;
          end else st <= S_FILL;
        end
        S_BYP: if (mem_ack) begin
          rdata_q <= lane_rd;
          st      <= S_DONE;
        end
        S_FILL: if (mem_ack) begin
          if (mem_err) begin
            vld_q[a_si][vway_q] <= 1'b0;
            if (!we_q) rdata_q <= '0;
            st <= S_DONE;
          end else begin
            if (fcnt == '0 && !we_q) rdata_q <= lane_rd;
            if (f_last) begin
              tag_q[vway_q][a_si] <= a_tg;
              vld_q[a_si][vway_q] <= 1'b1;
              lat_q <= we_q ? LAT_W'(LAT_SM) : LAT_W'(LAT_LM);
              st    <= S_WAIT;
            end else fcnt <= fcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (lat_q == '0) st <= S_DONE;
          else lat_q <= lat_q - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK) |-> $onehot0(hit_vec));
  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R3
  store_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && we_q) |=> (mem_req && mem_we));
  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({cnt_rd_hit != $past(cnt_rd_hit), cnt_rd_miss != $past(cnt_rd_miss),
                cnt_wr_hit != $past(cnt_wr_hit), cnt_wr_miss != $past(cnt_wr_miss)}) <= 1);
  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/tb_dcache_wt.sv
`timescale 1ns/1ps
module tb_dcache_wt;
  localparam int AW = 16, WORDS = 4, CW = 16;
  localparam int LH = 1, LM = 3, SH = 2, SM = 4;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic cache_en = 1, req_valid = 0, req_write = 0, req_inhibit = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [CW-1:0] c_rh, c_rm, c_wh, c_wm;

  dcache_wt #(.ADDR_W(AW), .WAYS(2), .SETS(4), .WORDS(WORDS), .CNT_W(CW),
              .LAT_LH(LH), .LAT_LM(LM), .LAT_SH(SH), .LAT_SM(SM)) dut (
    .clk(clk), .rst(rst), .cache_en(cache_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_inhibit(req_inhibit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm));

  // Memory model: zero-wait, upper half of the address space unmapped.
  logic [31:0] mem_arr [256];
  logic [AW-1:0] rlog [$];
  logic [AW-1:0] last_waddr;
  logic [3:0] last_be;
  int nwr = 0;
  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && mem_addr[AW-1];
  assign mem_rdata = mem_arr[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req && mem_we && !mem_addr[AW-1]) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem_arr[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      last_waddr <= mem_addr;
      last_be    <= mem_be;
      nwr        <= nwr + 1;
    end
    if (mem_req && !mem_we) rlog.push_back(mem_addr);
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  typedef struct {logic [31:0] d; bit cd; int lat; int acc; string r;} exp_t;
  exp_t q [$];
  int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;

  // Monitor: pop and compare as responses appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) chk(0, "R13 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk((cyc - e.acc) == e.lat, {e.r, " latency"}, cyc - e.acc, e.lat);
        if (e.cd) chk(rsp_rdata == e.d, {e.r, " data"}, rsp_rdata, e.d);
      end
    end
  end

  function automatic logic [31:0] lane(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off);
    if (sz == 0) return (w >> (8 * (3 - off))) & 32'hFF;
    if (sz == 1) return off[1] ? (w & 32'hFFFF) : (w >> 16);
    return w;
  endfunction

  // kind: 0 load hit, 1 load miss, 2 store hit, 3 store miss, 4 bypass, 5 failed refill
  task automatic acc(input bit we, input logic [1:0] sz, input logic [AW-1:0] a,
                     input logic [31:0] wd, input bit ci, input int kind,
                     input logic [31:0] ed, input string r);
    exp_t e;
    e.d = ed; e.cd = !we; e.r = r;
    case (kind)
      0: begin e.lat = LH + 2; e_rh++; end
      1: begin e.lat = LM + WORDS + 2; e_rm++; end
      2: begin e.lat = SH + 3; e_wh++; end
      3: begin e.lat = SM + WORDS + 3; e_wm++; end
      4: e.lat = 2;
      default: begin e.lat = 2; e_rm++; end
    endcase
    @(negedge clk);
    req_valid = 1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd; req_inhibit = ci;
    @(posedge clk); #1;
    e.acc = cyc;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R13 busy after accept", req_ready, 0);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
    $finish;
  end

  initial begin
    logic [31:0] old1, w114, w124;
    for (int i = 0; i < 256; i++) mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready && !rsp_valid, "R12 handshake idle", {req_ready, rsp_valid}, 2'b10);
    chk({c_rh, c_rm, c_wh, c_wm} == '0, "R12 counters zero", {c_rh, c_rm}, 0);

    // R5 / R9 load miss with critical word first
    rlog.delete();
    acc(0, 2, 16'h0008, 0, 0, 1, mem_arr[2], "R9 load miss word");
    chk(rlog.size() == 4, "R5 refill length", rlog.size(), 4);
    if (rlog.size() == 4) begin
      chk(rlog[0] == 16'h0008 && rlog[1] == 16'h000C, "R5 refill start", {rlog[0], rlog[1]}, 32'h0008_000C);
      chk(rlog[2] == 16'h0000 && rlog[3] == 16'h0004, "R5 refill wrap", {rlog[2], rlog[3]}, 32'h0000_0004);
    end

    // R6 big-endian lanes on hits
    acc(0, 0, 16'h0005, 0, 0, 0, lane(mem_arr[1], 0, 1), "R6 byte offset 1");
    acc(0, 1, 16'h0006, 0, 0, 0, lane(mem_arr[1], 1, 2), "R6 half offset 2");
    acc(0, 1, 16'h0004, 0, 0, 0, lane(mem_arr[1], 1, 0), "R6 half offset 0");

    // R7 hit served from cache, store hit merges one lane
    old1 = mem_arr[1];
    mem_arr[1] = 32'hDEAD_BEEF;
    acc(0, 2, 16'h0004, 0, 0, 0, old1, "R7 hit from cache");
    acc(1, 0, 16'h0007, 32'h0000_005A, 0, 2, 0, "R3 store hit");
    chk(last_waddr == 16'h0004 && last_be == 4'b0001, "R6 byte enables", {last_waddr, last_be}, {16'h0004, 4'b0001});
    chk(mem_arr[1] == 32'hDEAD_BE5A, "R3 write-through", mem_arr[1], 32'hDEAD_BE5A);
    acc(0, 2, 16'h0004, 0, 0, 0, {old1[31:8], 8'h5A}, "R7 merged lane");

    // R1 / R11 set conflict and LRU
    acc(0, 2, 16'h0040, 0, 0, 1, mem_arr[16], "R1 second way fill");
    acc(0, 2, 16'h0000, 0, 0, 0, mem_arr[0], "R1 both tags resident");
    acc(0, 2, 16'h0080, 0, 0, 1, mem_arr[32], "R11 third tag miss");
    acc(0, 2, 16'h0000, 0, 0, 0, mem_arr[0], "R11 recent line kept");
    acc(0, 2, 16'h0040, 0, 0, 1, mem_arr[16], "R11 LRU line evicted");

    // R4 store miss allocates
    w114 = mem_arr[16'h114 >> 2];
    acc(1, 1, 16'h0116, 32'h0000_1234, 0, 3, 0, "R4 store miss");
    chk(last_be == 4'b0011, "R6 half enables", last_be, 4'b0011);
    acc(0, 2, 16'h0114, 0, 0, 0, {w114[31:16], 16'h1234}, "R4 allocated line hit");

    // R2 bypass paths
    cache_en = 0;
    acc(0, 2, 16'h0120, 0, 0, 4, mem_arr[16'h120 >> 2], "R2 disabled load");
    cache_en = 1;
    acc(0, 2, 16'h0120, 0, 0, 1, mem_arr[16'h120 >> 2], "R2 no allocation");
    w124 = mem_arr[16'h124 >> 2];
    acc(1, 2, 16'h0124, 32'hCAFE_F00D, 1, 4, 0, "R2 inhibited store");
    chk(mem_arr[16'h124 >> 2] == 32'hCAFE_F00D, "R2 inhibited store reached memory", mem_arr[16'h124 >> 2], 32'hCAFE_F00D);
    acc(0, 2, 16'h0124, 0, 0, 0, w124, "R2 cache untouched");

    // R8 refill into unmapped region
    acc(0, 2, 16'h8030, 0, 0, 5, 0, "R8 failed refill");
    acc(0, 2, 16'h8030, 0, 0, 5, 0, "R8 still misses");

    // R10 counters
    chk(c_rh == CW'(e_rh), "R10 load hits", c_rh, e_rh);
    chk(c_rm == CW'(e_rm), "R10 load misses", c_rm, e_rm);
    chk(c_wh == CW'(e_wh), "R10 store hits", c_wh, e_wh);
    chk(c_wm == CW'(e_wm), "R10 store misses", c_wm, e_wm);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule